// File: doc/BRIEF.md
# Folded Pipelined FIR Filter

This block is a direct-form finite impulse response filter built for high clock rates. A delay line holds one register per tap. Each coefficient has its own constant multiplier, and the weighted samples are summed by an adder tree that has a register after every level. The coefficients are fixed when the design is elaborated.

When the impulse response is mirror-symmetric, the two samples that share a coefficient are added together before the multiply, so only half as many multipliers are needed. When the response is anti-symmetric, the second sample is subtracted instead. A clock enable sets the sample rate: on a cycle where it is low, nothing in the filter moves. Tap count, data width, coefficient width, input signedness and output width are parameters.

Top module: `sym_fir_filter`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, `dout` is 0 and `dout_valid` is 0.
- R2: After the n-th enabled edge since reset, `dout` holds the filter result for the window of samples that ends with sample n-LAT. Here LAT = 3 + L, L = ceil(log2(M)), and M is the multiplier count (M = TAPS unfolded, M = ceil(TAPS/2) folded). Window samples from before the first sample count as 0.
- R3: With `FOLD` = FOLD_MIRROR, tap j and tap TAPS-1-j both use coefficient c[j]. Coefficient c[k] sits at bits [k*COEF_W +: COEF_W] of `COEFS` as a two's complement value. Only the entries k < M are used.
- R4: With `FOLD` = FOLD_NEGATE, tap TAPS-1-j uses -c[j], formed by subtracting the far sample in the pre-adder.
- R5: With an odd tap count in a folded mode, the centre tap (TAPS-1)/2 is not paired and uses its own coefficient c[(TAPS-1)/2].
- R6: With `FOLD` = FOLD_NONE, every tap k uses its own c[k], for all TAPS entries.
- R7: With `SIGNED_IN` = 1, `din` is read as two's complement. With `SIGNED_IN` = 0, it is read as an unsigned number.
- R8: The full-precision result width is FULL_W = DATA_W + 2 + COEF_W + L. No input sequence, including runs at the extreme input codes, overflows it.
- R9: When OUT_W < FULL_W, `dout` is the full result shifted arithmetically right by FULL_W-OUT_W, which rounds toward minus infinity.
- R10: On a cycle where `ce` is low, the next cycle shows `dout` unchanged and `dout_valid` low.
- R11: `dout_valid` is high for exactly one cycle after each enabled edge, but only once at least TAPS+LAT enabled edges have occurred since reset. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Sample enable; the pipeline advances only on edges where it is high |
| din | input | DATA_W | Input sample |
| dout | output | OUT_W | Filter output, full precision or truncated |
| dout_valid | output | 1 | One-cycle strobe marking a new output with a full window |

## Verification
The checks that run on every cycle cover the stall behaviour and the valid strobe. No output is allowed to change, and no strobe to appear, after a cycle with the enable low. The strobe must appear after every enabled edge once the fill count has been reached, and never before it. The arithmetic cannot be shown by a cycle-local property: the folding signs, the unpaired centre tap, unsigned input, truncation and latency are shown only by the bench. The bench runs three configurations against a model of the convolution, using impulses, extreme input codes and random data under an irregular enable pattern.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;

  typedef enum logic [1:0] {
    FOLD_NONE   = 2'd0,
    FOLD_MIRROR = 2'd1,
    FOLD_NEGATE = 2'd2
  } fold_e;

  function automatic int mult_count(input int taps, input fold_e fold);
    return (fold == FOLD_NONE) ? taps : (taps + 1) / 2;
  endfunction

  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

endpackage

// File: rtl/fir_fold_line.sv
module fir_fold_line
  import sym_fir_pkg::*;
#(
  parameter int    TAPS      = 7,
  parameter int    DATA_W    = 8,
  parameter bit    SIGNED_IN = 1'b1,
  parameter fold_e FOLD      = FOLD_MIRROR,
  parameter int    NMUL      = 4,
  parameter int    PW        = DATA_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [DATA_W-1:0]    din,
  output logic signed [PW-1:0] folded [NMUL]
);
  localparam int XW = DATA_W + 1;

  logic signed [XW-1:0] line_q [TAPS];
  logic signed [XW-1:0] din_x;
  logic signed [PW-1:0] fold_d [NMUL];

  generate
    if (SIGNED_IN) begin : g_sext
      assign din_x = {din[DATA_W-1], din};
    end else begin : g_zext
      assign din_x = {1'b0, din};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) line_q[i] <= '0;
    end else if (ce) begin
      line_q[0] <= din_x;
      for (int i = 1; i < TAPS; i++) line_q[i] <= line_q[i-1];
    end
  end

  generate
    for (genvar k = 0; k < NMUL; k++) begin : g_fold
      if (FOLD == FOLD_NONE || (2 * k + 1) == TAPS) begin : g_single
        assign fold_d[k] = PW'(line_q[k]);
      end else begin : g_pair
        logic signed [PW-1:0] near_e, far_e;
        assign near_e = PW'(line_q[k]);
        assign far_e  = PW'(line_q[TAPS-1-k]);
        if (FOLD == FOLD_NEGATE) begin : g_sub
          assign fold_d[k] = near_e - far_e;
        end else begin : g_add
          assign fold_d[k] = near_e + far_e;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NMUL; k++) folded[k] <= '0;
    end else if (ce) begin
      for (int k = 0; k < NMUL; k++) folded[k] <= fold_d[k];
    end
  end

endmodule

// File: rtl/fir_kcm_bank.sv
module fir_kcm_bank #(
  parameter int                 NMUL   = 4,
  parameter int                 TAPS   = 7,
  parameter int                 PW     = 10,
  parameter int                 COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  parameter int                 PRODW  = PW + COEF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [PW-1:0]    folded [NMUL],
  output logic signed [PRODW-1:0] prod   [NMUL]
);
  logic signed [COEF_W-1:0] coef [NMUL];

  generate
    for (genvar k = 0; k < NMUL; k++) begin : g_coef
      assign coef[k] = $signed(COEFS[k*COEF_W +: COEF_W]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NMUL; k++) prod[k] <= '0;
    end else if (ce) begin
      for (int k = 0; k < NMUL; k++) prod[k] <= PRODW'(folded[k]) * PRODW'(coef[k]);
    end
  end

endmodule

// File: rtl/fir_sum_tree.sv
module fir_sum_tree #(
  parameter int N      = 4,
  parameter int LEVELS = 2,
  parameter int IN_W   = 18,
  parameter int SUM_W  = IN_W + LEVELS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic signed [IN_W-1:0] terms [N],
  output logic signed [SUM_W-1:0] total
);
  localparam int NPAD = 1 << LEVELS;

  generate
    if (LEVELS == 0) begin : g_flat
      assign total = SUM_W'(terms[0]);
    end else begin : g_tree
      logic signed [SUM_W-1:0] leaf   [NPAD];
      logic signed [SUM_W-1:0] node_d [NPAD-1];
      logic signed [SUM_W-1:0] node_q [NPAD-1];

      for (genvar i = 0; i < NPAD; i++) begin : g_leaf
        if (i < N) begin : g_used
          assign leaf[i] = SUM_W'(terms[i]);
        end else begin : g_pad
          assign leaf[i] = '0;
        end
      end

      for (genvar i = 0; i < NPAD - 1; i++) begin : g_node
        localparam int LC = 2 * i + 1;
        if (LC >= NPAD - 1) begin : g_from_leaf
          assign node_d[i] = leaf[LC-NPAD+1] + leaf[LC-NPAD+2];
        end else begin : g_from_node
          assign node_d[i] = node_q[LC] + node_q[LC+1];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < NPAD - 1; i++) node_q[i] <= '0;
        end else if (ce) begin
          for (int i = 0; i < NPAD - 1; i++) node_q[i] <= node_d[i];
        end
      end

      assign total = node_q[0];
    end
  endgenerate

endmodule

// File: rtl/sym_fir_filter.sv
module sym_fir_filter
  import sym_fir_pkg::*;
#(
  parameter int    TAPS      = 7,
  parameter int    DATA_W    = 8,
  parameter int    COEF_W    = 8,
  parameter bit    SIGNED_IN = 1'b1,
  parameter fold_e FOLD      = FOLD_MIRROR,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {8'h00, 8'h00, 8'h00, 8'h40, 8'h20, 8'hF0, 8'h08},
  parameter int    OUT_W     = DATA_W + 2 + COEF_W + tree_levels(mult_count(TAPS, FOLD))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  output logic [OUT_W-1:0]  dout,
  output logic              dout_valid
);
  localparam int PW     = DATA_W + 2;
  localparam int NMUL   = mult_count(TAPS, FOLD);
  localparam int LEVELS = tree_levels(NMUL);
  localparam int PRODW  = PW + COEF_W;
  localparam int FULL_W = PRODW + LEVELS;
  localparam int LAT    = 3 + LEVELS;
  localparam int FILL   = TAPS + LAT;
  localparam int CNT_W  = $clog2(FILL + 1);

  logic signed [PW-1:0]     folded [NMUL];
  logic signed [PRODW-1:0]  prod   [NMUL];
  logic signed [FULL_W-1:0] total;
  logic [CNT_W-1:0]         fill_q;

  fir_fold_line #(
    .TAPS(TAPS), .DATA_W(DATA_W), .SIGNED_IN(SIGNED_IN),
    .FOLD(FOLD), .NMUL(NMUL), .PW(PW)
  ) u_line (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .folded(folded)
  );

  fir_kcm_bank #(
    .NMUL(NMUL), .TAPS(TAPS), .PW(PW), .COEF_W(COEF_W),
    .COEFS(COEFS), .PRODW(PRODW)
  ) u_mul (
    .clk(clk), .rst(rst), .ce(ce), .folded(folded), .prod(prod)
  );

  fir_sum_tree #(
    .N(NMUL), .LEVELS(LEVELS), .IN_W(PRODW), .SUM_W(FULL_W)
  ) u_tree (
    .clk(clk), .rst(rst), .ce(ce), .terms(prod), .total(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
      fill_q     <= '0;
    end else begin
      dout_valid <= ce && (fill_q >= CNT_W'(FILL - 1));
      if (ce) begin
        dout <= total[FULL_W-1 -: OUT_W];
        if (fill_q < CNT_W'(FILL)) fill_q <= fill_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int FILL  = 12,
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic [OUT_W-1:0] dout,
  input logic             dout_valid
);
  localparam int CW = $clog2(FILL + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (ce && seen_q < CW'(FILL)) seen_q <= seen_q + 1'b1;
  end

  assert_stall_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !dout_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(dout));

  assert_no_early_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> (seen_q >= CW'(FILL)));

  assert_strobe_when_full_R11: assert property (@(posedge clk) disable iff (rst)
    (ce && seen_q >= CW'(FILL - 1)) |=> dout_valid);

endmodule

bind sym_fir_filter fir_checker #(.FILL(FILL), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .dout(dout), .dout_valid(dout_valid)
);

// File: tb/sim_sym_fir_filter.sv
module sim_sym_fir_filter;
  import sym_fir_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce  = 1'b0;
  logic [7:0] din = '0;
  always #5 clk = ~clk;

  logic [19:0] dout0; logic v0;
  logic [11:0] dout1; logic v1;
  logic [20:0] dout2; logic v2;

  // u0: 7 taps mirrored, signed, full precision (L=2, LAT=5)
  sym_fir_filter #(.TAPS(7), .DATA_W(8), .COEF_W(8), .SIGNED_IN(1'b1), .FOLD(FOLD_MIRROR),
    .COEFS({8'h37, 8'h37, 8'h37, 8'h64, 8'h25, 8'hF6, 8'h03})) u0 (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout0), .dout_valid(v0));
  // u1: 6 taps negated, unsigned, 12-bit output from FULL_W=20 (L=2, LAT=5)
  sym_fir_filter #(.TAPS(6), .DATA_W(8), .COEF_W(8), .SIGNED_IN(1'b0), .FOLD(FOLD_NEGATE),
    .COEFS({8'h11, 8'h11, 8'h11, 8'hFB, 8'h4D, 8'h80}), .OUT_W(12)) u1 (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout1), .dout_valid(v1));
  // u2: 5 taps unfolded, signed, full precision 21 bits (L=3, LAT=6)
  sym_fir_filter #(.TAPS(5), .DATA_W(8), .COEF_W(8), .SIGNED_IN(1'b1), .FOLD(FOLD_NONE),
    .COEFS({8'h7F, 8'h80, 8'h32, 8'hFE, 8'h01})) u2 (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout2), .dout_valid(v2));

  int checks = 0, errors = 0, ev = 0;
  int hist [0:1023];
  int eff0 [7] = '{3, -10, 37, 100, 37, -10, 3};
  int eff1 [6] = '{-128, 77, -5, 5, -77, 128};
  int eff2 [5] = '{1, -2, 50, -128, 127};
  int taps [3] = '{7, 6, 5};
  int lat  [3] = '{5, 5, 6};
  longint prev [3];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint coef(input int u, input int j);
    if (u == 0) return eff0[j];
    if (u == 1) return eff1[j];
    return eff2[j];
  endfunction

  // Convolution over the window ending at sample m (R2); samples before 1 are zero.
  function automatic longint model(input int u, input int m);
    longint acc = 0;
    for (int j = 0; j < taps[u]; j++) begin
      if (m - j >= 1) begin
        longint x;
        x = (u == 1) ? longint'(hist[m-j] & 255) : longint'($signed(8'(hist[m-j])));
        acc += coef(u, j) * x;
      end
    end
    return (u == 1) ? (acc >>> 8) : acc;  // R9: 20-bit result to 12 bits
  endfunction

  function automatic longint outv(input int u);
    if (u == 0) return longint'($signed(dout0));
    if (u == 1) return longint'($signed(dout1));
    return longint'($signed(dout2));
  endfunction

  function automatic bit validv(input int u);
    return (u == 0) ? v0 : ((u == 1) ? v1 : v2);
  endfunction

  task automatic evaluate(input bit c);
    for (int u = 0; u < 3; u++) begin
      string tag;
      tag = (u == 0) ? "R2 R3 R5 R8" : ((u == 1) ? "R2 R4 R7 R9" : "R2 R6 R8");
      if (c) begin
        bit ev_ok;
        ev_ok = (ev >= taps[u] + lat[u]);
        chk(validv(u) == ev_ok, "R11 strobe", longint'(validv(u)), longint'(ev_ok));
        if (ev_ok) chk(outv(u) == model(u, ev - lat[u]), tag, outv(u), model(u, ev - lat[u]));
      end else begin
        chk(!validv(u), "R10 strobe", longint'(validv(u)), 0);
        chk(outv(u) == prev[u], "R10 hold", outv(u), prev[u]);
      end
      prev[u] = outv(u);
    end
  endtask

  task automatic run(input bit c, input logic [7:0] d);
    ce = c; din = d;
    @(posedge clk);
    if (c) begin ev++; hist[ev] = int'(d); end
    @(negedge clk);
    evaluate(c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int u = 0; u < 3; u++) begin
      chk(outv(u) == 0, "R1 dout", outv(u), 0);
      chk(!validv(u), "R1 valid", longint'(validv(u)), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int u = 0; u < 3; u++) begin
      chk(outv(u) == 0 && !validv(u), "R1 after", outv(u), 0);
      prev[u] = outv(u);
    end
    // impulse: exposes each effective coefficient in turn (R3 R4 R5 R6)
    run(1'b1, 8'd1);
    for (int i = 0; i < 20; i++) run(1'b1, 8'd0);
    // extreme codes for overflow headroom (R8 R7)
    for (int i = 0; i < 20; i++) run(1'b1, 8'h7F);
    for (int i = 0; i < 20; i++) run(1'b1, 8'h80);
    for (int i = 0; i < 20; i++) run(1'b1, (i % 2) ? 8'h80 : 8'hFF);
    // random data under an irregular enable (R10 R11)
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run(lf[3] | lf[9], lf[15:8]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule